// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Core

This block is a small processor core that runs each instruction as a fixed sequence of four register transfers. A program counter, a memory address register, an instruction register, two operand latches and an eight-entry register file are built around a two-function ALU. A four-state controller moves through the sequence one state per clock. Instructions and data share one sixteen-word internal memory, which is word addressed. The memory is filled through a preload port while reset is held. After that the core runs until it fetches a HALT instruction.

The controller states are `ST_T0` (capture address), `ST_T1` (fetch and step the PC), `ST_T2` (latch operands) and `ST_T3` (write back). There are four transitions. `ST_T0`→`ST_T1` is taken when the core is not halted. `ST_T1`→`ST_T2` is always taken. `ST_T2`→`ST_T3` is taken for any opcode except HALT. `ST_T3`→`ST_T0` is always taken. A HALT opcode takes the halt transition `ST_T2`→`ST_T0`, and the core then rests in `ST_T0` with the halted flag set. A debug port reads any register combinationally, so a bench or a debugger can inspect the results.

Top module: `mc_core`

## Requirements
- R1: After reset is released, the controller passes through ST_T0, ST_T1, ST_T2 and ST_T3 in that order, one state per clock, so each non-HALT instruction takes exactly four clocks. If n instructions come before the first HALT, `halted` rises after clock edge 4n+3 counted from the release of reset.
- R2: In ST_T0 the memory address register takes the program counter value. While halted, it is not loaded.
- R3: In ST_T1 the instruction register takes the memory word at the address register, and on the same edge the PC increments by one modulo 16 (15 wraps to 0).
- R4: In ST_T2 the registers named by rs1 (bits [8:6]) and rs2 (bits [5:3]) are latched into operand latches A and B on the same edge. The latches hold in every other state.
- R5: In ST_T3, opcode 0 (ADD, bits [15:12]) writes A+B, and opcode 1 (SUB) writes A−B modulo 2^16, into the register named by rd (bits [11:9]). Any register, r0 included, may be a destination. Bits [2:0] are ignored.
- R6: Opcode 2 (LOAD) writes into rd the memory word at address (A+B) modulo 16.
- R7: Opcode 3 (STORE) writes the value of register rd to memory at address (A+B) modulo 16 and writes no register.
- R8: Opcode 15 (HALT) leaves the core in ST_T0 with `halted` high until reset, and no register changes after that. Opcodes 4 to 14 change neither a register nor memory.
- R9: Synchronous reset clears the PC, the address and instruction registers, A, B and all eight registers to zero, returns the controller to ST_T0 and drives `halted` low.
- R10: The preload port writes memory only while `rst` is high. A preload write while the core runs has no effect on memory.
- R11: `dbg_word` shows the current value of the register selected by `dbg_sel`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write strobe, honoured only during reset |
| pre_addr | input | 4 | Preload word address |
| pre_data | input | 16 | Preload word |
| halted | output | 1 | High once a HALT has executed, until reset |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_word | output | 16 | Contents of the selected register |

## Verification
The hardest situation to reach from the ports is a PC wrap. The registers start at zero and no instruction carries an immediate value, so every constant has to come from instruction words that are loaded as data. The wrap program builds the HALT word in a register, doubling a no-op-coded word with ADD, and stores it over address 0. It then runs through sixteen executed words so that the wrapped fetch finds the HALT. That one run also exercises the unknown opcode, store-then-fetch through the shared memory, and a long halt timing count.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        ST_T0,
        ST_T1,
        ST_T2,
        ST_T3
    } step_t;

    typedef enum logic {
        ALU_ADD,
        ALU_SUB
    } alu_op_t;

    localparam logic [3:0] OPC_ADD   = 4'd0;
    localparam logic [3:0] OPC_SUB   = 4'd1;
    localparam logic [3:0] OPC_LOAD  = 4'd2;
    localparam logic [3:0] OPC_STORE = 4'd3;
    localparam logic [3:0] OPC_HALT  = 4'd15;

    typedef struct packed {
        logic    reg_wr;
        logic    mem_rd;
        logic    mem_wr;
        alu_op_t alu_op;
        logic    halt;
    } ctrl_t;

    function automatic ctrl_t decode_class(input logic [3:0] opc);
        ctrl_t c;
        c = '{reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, alu_op: ALU_ADD, halt: 1'b0};
        unique case (opc)
            OPC_ADD:   c.reg_wr = 1'b1;
            OPC_SUB:   begin c.reg_wr = 1'b1; c.alu_op = ALU_SUB; end
            OPC_LOAD:  begin c.reg_wr = 1'b1; c.mem_rd = 1'b1; end
            OPC_STORE: c.mem_wr = 1'b1;
            OPC_HALT:  c.halt = 1'b1;
            default:   c.halt = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int RAW     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RAW-1:0]    waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RAW-1:0]    ra1,
    output logic [DATA_W-1:0] rd1,
    input  logic [RAW-1:0]    ra2,
    output logic [DATA_W-1:0] rd2,
    input  logic [RAW-1:0]    ra3,
    output logic [DATA_W-1:0] rd3
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];
    assign rd3 = regs_q[ra3];

    AST_RF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_q));                               // R5

    AST_RF_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> ($countones($past(regs_q) ^ regs_q) <= DATA_W));  // R5

endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
    parameter int DATA_W    = 16,
    parameter int MEM_DEPTH = 16,
    localparam int MAW      = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [MAW-1:0]    pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    input  logic              we,
    input  logic [MAW-1:0]    waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MAW-1:0]    raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words_q [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            if (pre_we) begin
                words_q[pre_addr] <= pre_data;
            end
        end else if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    assign rdata = words_q[raddr];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
        endcase
    end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] opc,
    output step_t      state,
    output logic       halted,
    output logic       ld_mar,
    output logic       ld_ir,
    output logic       ld_ab,
    output logic       rf_we,
    output logic       mem_we,
    output logic       wb_from_mem,
    output alu_op_t    alu_op
);

    step_t state_q, state_d;
    logic  halted_q, halted_d;
    ctrl_t cls;

    assign cls = decode_class(opc);

    always_comb begin
        state_d  = state_q;
        halted_d = halted_q;
        unique case (state_q)
            ST_T0: if (!halted_q) state_d = ST_T1;
            ST_T1: state_d = ST_T2;
            ST_T2: begin
                if (cls.halt) begin
                    state_d  = ST_T0;
                    halted_d = 1'b1;
                end else begin
                    state_d = ST_T3;
                end
            end
            ST_T3: state_d = ST_T0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_T0;
            halted_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            halted_q <= halted_d;
        end
    end

    always_comb begin
        ld_mar      = (state_q == ST_T0) && !halted_q;
        ld_ir       = (state_q == ST_T1);
        ld_ab       = (state_q == ST_T2);
        rf_we       = (state_q == ST_T3) && cls.reg_wr;
        mem_we      = (state_q == ST_T3) && cls.mem_wr;
        wb_from_mem = cls.mem_rd;
        alu_op      = cls.alu_op;
    end

    assign state  = state_q;
    assign halted = halted_q;

    AST_T0_TO_T1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_T0 && !halted_q) |=> (state_q == ST_T1));  // R1
    AST_T1_TO_T2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_T1) |=> (state_q == ST_T2));               // R1
    AST_T3_TO_T0: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_T3) |=> (state_q == ST_T0));               // R1
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> (halted_q && state_q == ST_T0));             // R8
    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        halted_q |-> (!rf_we && !mem_we));                        // R8

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MEM_DEPTH = 16,
    parameter int NUM_REGS  = 8,
    localparam int MAW      = $clog2(MEM_DEPTH),
    localparam int RAW      = $clog2(NUM_REGS),
    localparam int OPC_LSB  = DATA_W - 4,
    localparam int RD_LSB   = OPC_LSB - RAW,
    localparam int RS1_LSB  = RD_LSB - RAW,
    localparam int RS2_LSB  = RS1_LSB - RAW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [MAW-1:0]    pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    output logic              halted,
    input  logic [RAW-1:0]    dbg_sel,
    output logic [DATA_W-1:0] dbg_word
);

    logic [MAW-1:0]    pc_q, mar_q;
    logic [DATA_W-1:0] ir_q, a_q, b_q;

    step_t   state;
    logic    ld_mar, ld_ir, ld_ab, rf_we, mem_we, wb_from_mem;
    alu_op_t alu_op;

    logic [RAW-1:0]    f_rd, f_rs1, f_rs2, rf_ra1;
    logic [DATA_W-1:0] rf_rd1, rf_rd2, alu_y, mem_rdata, wb_data;
    logic [MAW-1:0]    mem_raddr;

    assign f_rd  = ir_q[RD_LSB  +: RAW];
    assign f_rs1 = ir_q[RS1_LSB +: RAW];
    assign f_rs2 = ir_q[RS2_LSB +: RAW];

    mc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .opc         (ir_q[OPC_LSB +: 4]),
        .state       (state),
        .halted      (halted),
        .ld_mar      (ld_mar),
        .ld_ir       (ld_ir),
        .ld_ab       (ld_ab),
        .rf_we       (rf_we),
        .mem_we      (mem_we),
        .wb_from_mem (wb_from_mem),
        .alu_op      (alu_op)
    );

    // Port 1 serves rs1 for the operand latch, and rd as store data in T3
    assign rf_ra1 = (state == ST_T3) ? f_rd : f_rs1;

    mc_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (f_rd),
        .wdata (wb_data),
        .ra1   (rf_ra1),
        .rd1   (rf_rd1),
        .ra2   (f_rs2),
        .rd2   (rf_rd2),
        .ra3   (dbg_sel),
        .rd3   (dbg_word)
    );

    mc_alu #(.DATA_W(DATA_W)) u_alu (
        .op (alu_op),
        .a  (a_q),
        .b  (b_q),
        .y  (alu_y)
    );

    // One memory port: instruction fetch in T1, data address otherwise
    assign mem_raddr = (state == ST_T1) ? mar_q : alu_y[MAW-1:0];

    mc_mem #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .we       (mem_we),
        .waddr    (alu_y[MAW-1:0]),
        .wdata    (rf_rd1),
        .raddr    (mem_raddr),
        .rdata    (mem_rdata)
    );

    assign wb_data = wb_from_mem ? mem_rdata : alu_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else begin
            if (ld_mar) begin
                mar_q <= pc_q;
            end
            if (ld_ir) begin
                ir_q <= mem_rdata;
                pc_q <= pc_q + MAW'(1);
            end
            if (ld_ab) begin
                a_q <= rf_rd1;
                b_q <= rf_rd2;
            end
        end
    end

    AST_MAR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T0 && !halted) |=> (mar_q == $past(pc_q)));          // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T1) |=> (pc_q == MAW'($past(pc_q) + 1'b1)));       // R3
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_T1) |=> $stable(pc_q));                             // R3
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_T2) |=> ($stable(a_q) && $stable(b_q)));            // R4

endmodule

// File: tb/sim_mc_core.sv
module sim_mc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pre_we = 1'b0;
    logic [3:0]  pre_addr = '0;
    logic [15:0] pre_data = '0;
    logic        halted;
    logic [2:0]  dbg_sel = '0;
    logic [15:0] dbg_word;

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] img   [16];
    logic [15:0] exp_r [8];
    int          exp_n;

    always #5 clk = ~clk;

    mc_core u0 (
        .clk      (clk),
        .rst      (rst),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .halted   (halted),
        .dbg_sel  (dbg_sel),
        .dbg_word (dbg_word)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Instruction-level reference model, built from the requirements
    task automatic model();
        logic [15:0] m [16];
        logic [15:0] r [8];
        logic [3:0]  pc;
        logic [15:0] ir, a, b;
        for (int i = 0; i < 16; i++) m[i] = img[i];
        for (int i = 0; i < 8; i++) r[i] = '0;
        pc = '0;
        exp_n = 0;
        for (int step = 0; step < 200; step++) begin
            ir = m[pc];
            pc = pc + 4'd1;
            if (ir[15:12] == 4'd15) break;
            a = r[ir[8:6]];
            b = r[ir[5:3]];
            case (ir[15:12])
                4'd0: r[ir[11:9]] = a + b;
                4'd1: r[ir[11:9]] = a - b;
                4'd2: r[ir[11:9]] = m[4'(a + b)];
                4'd3: m[4'(a + b)] = r[ir[11:9]];
                default: ;
            endcase
            exp_n++;
        end
        for (int i = 0; i < 8; i++) exp_r[i] = r[i];
    endtask

    task automatic preload();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            pre_we   = 1'b1;
            pre_addr = 4'(i);
            pre_data = img[i];
            @(negedge clk);
        end
        pre_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_img();
        for (int i = 0; i < 16; i++) img[i] = 16'h0000;
    endtask

    // Releases reset, times the halt and compares the register file
    task automatic run_and_check(input string tag);
        int edges;
        logic [15:0] snap [8];
        model();
        rst = 1'b0;
        edges = 0;
        for (int k = 0; k < 1000; k++) begin
            @(posedge clk);
            edges++;
            #1;
            if (halted) break;
        end
        check({"R1 halt edge ", tag}, 16'(edges), 16'(4 * exp_n + 3));
        for (int i = 0; i < 8; i++) begin
            dbg_sel = 3'(i);
            #1;
            snap[i] = dbg_word;
            check({"R11 register ", tag}, dbg_word, exp_r[i]);
        end
        repeat (8) @(posedge clk);
        #1;
        check({"R8 halted stays ", tag}, 16'(halted), 16'd1);
        for (int i = 0; i < 8; i++) begin
            dbg_sel = 3'(i);
            #1;
            check({"R8 frozen ", tag}, dbg_word, snap[i]);
        end
    endtask

    // R9: a reset after a run clears every register and the halt flag
    task automatic t_reset_state();
        clear_img();
        img[0] = 16'hF000;
        preload();
        check("R9 halted low in reset", 16'(halted), 16'd0);
        for (int i = 0; i < 8; i++) begin
            dbg_sel = 3'(i);
            #1;
            check("R9 register cleared", dbg_word, 16'h0000);
        end
        run_and_check("halt at 0");
    endtask

    // R2 R3 R4 R5: ADD/SUB chain, negative wrap, rd equal to a source
    task automatic t_arith();
        clear_img();
        img[0] = 16'h2200;
        img[1] = 16'h0448;
        img[2] = 16'h1688;
        img[3] = 16'h1808;
        img[4] = 16'h0918;
        img[5] = 16'hF000;
        preload();
        run_and_check("R5 arith");
    endtask

    // R6 R7: store then load back; the store leaves rd unchanged
    task automatic t_memops();
        clear_img();
        img[0] = 16'h2203;
        img[1] = 16'h2408;
        img[2] = 16'h3448;
        img[3] = 16'h2A48;
        img[4] = 16'hF000;
        preload();
        run_and_check("R6 R7 memops");
    endtask

    // R10: preload strobes while running do not reach memory
    task automatic t_preload_locked();
        clear_img();
        img[0]  = 16'h2205;
        img[1]  = 16'h2448;
        img[2]  = 16'hF000;
        img[10] = 16'h1234;
        preload();
        pre_we   = 1'b1;
        pre_addr = 4'd10;
        pre_data = 16'hDEAD;
        run_and_check("R10 preload locked");
        pre_we = 1'b0;
        dbg_sel = 3'd2;
        #1;
        check("R10 loaded word", dbg_word, 16'h1234);
    endtask

    // R3 wrap and R8 unknown opcode: HALT stored over word 0, reached after PC wraps
    task automatic t_wrap_unknown();
        clear_img();
        img[0]  = 16'h220F;
        img[1]  = 16'h2E08;
        img[2]  = 16'h0FF8;
        img[3]  = 16'h3E00;
        img[15] = 16'h7800;
        preload();
        run_and_check("R3 wrap R8 unknown");
        dbg_sel = 3'd7;
        #1;
        check("R8 built halt word", dbg_word, 16'hF000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_arith();
        t_reset_state();
        t_memops();
        t_preload_locked();
        t_wrap_unknown();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule